// File: doc/BRIEF.md
# Parallel NOR Flash Bus Front End

This block is the device-side front end of an asynchronous parallel NOR memory bus. It is built as synchronous logic on a fast internal clock that oversamples the active-low strobes. Chip enable, write enable and hardware reset each pass through a two-flop synchroniser and then a stability filter, which drops short glitches. Output enable is synchronised but not filtered, so that the data drivers can be released quickly.

From the conditioned strobes the block classifies every clock as standby, read, write, output disable or reset. Write cycles are framed by the combined strobe (chip enable OR write enable). The address is taken when that strobe falls, which is when the later of the two goes low. The data is taken when it rises, which is when the earlier of the two goes high. The result goes to the command interpreter as a single-clock pulse. For reads, the block drives a read-active level, a data-output enable and the word offset within an 8-word page.

The write hand-off is a valid-only stream with no ready. The external bus cannot be stalled, so the consumer must accept every `wr_valid` pulse in the clock in which it appears. `wr_addr` and `wr_data` hold their values until the next capture.

Top module: `nor_bus_front`

## Requirements
- R1: While `rst_n` is low and in the clock after it rises, `cycle_kind` is 0 (standby), and `wr_valid`, `wr_error`, `rd_active`, `dq_oe` and `page_offset` are all 0.
- R2: A low or high pulse on chip enable, write enable or hardware reset that lasts FILT_CYC-1 sample clocks or fewer has no effect on `cycle_kind` or on write capture. A pulse that lasts FILT_CYC clocks is accepted.
- R3: A chip enable, write enable or hardware reset level sampled at clock edge n is reflected in `cycle_kind` from edge n+FILT_CYC+2 onward.
- R4: `cycle_kind` codes, in priority order: 4 = reset (hardware reset low), 0 = standby (chip enable high), 2 = write (write enable low), 1 = read (output enable low), 3 = output disable (otherwise).
- R5: `rd_active` is high exactly when `cycle_kind` is 1. `dq_oe` is `rd_active` gated by the synchronised output enable. It is low after the second clock edge that samples output enable high, and it is never high in standby or output disable.
- R6: `page_offset` is the low three address bits registered one clock earlier, which selects a word in an 8-word page.
- R7: On a write, `wr_addr` is the address sampled when the filtered combined strobe falls, and `wr_data` is the data sampled when it rises. This holds whichever of chip enable and write enable moves first.
- R8: Each completed write produces exactly one `wr_valid` pulse one clock wide, with no back-pressure.
- R9: If output enable is low when the combined strobe falls, or at any time while a write is armed, the write is discarded: `wr_error` pulses once and no `wr_valid` follows.
- R10: Hardware reset low abandons an armed write silently: no `wr_valid` and no `wr_error` result, even after reset is released.
- R11: `wr_valid` and `wr_error` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset of the block logic |
| chip_en_n | input | 1 | Bus chip enable, active low, asynchronous |
| out_en_n | input | 1 | Bus output enable, active low, asynchronous |
| wr_en_n | input | 1 | Bus write enable, active low, asynchronous |
| hw_rst_n | input | 1 | Bus hardware reset, active low, asynchronous |
| addr_in | input | AW | Bus address |
| data_in | input | DW | Bus write data |
| wr_valid | output | 1 | One-clock pulse: captured write is ready |
| wr_addr | output | AW | Captured write address |
| wr_data | output | DW | Captured write data |
| wr_error | output | 1 | One-clock pulse: write discarded because output enable was low |
| rd_active | output | 1 | Bus is in a read cycle |
| dq_oe | output | 1 | Data output driver enable |
| page_offset | output | PW | Word offset within the read page |
| cycle_kind | output | 3 | Current bus cycle classification |

## Verification
The assertions assume that `rst_n` is held low for several clocks from time zero, so the synchroniser history is known before any property is enabled. They also assume that the address and data buses stay stable from the strobe edge until FILT_CYC+3 clocks after it, because the buses are sampled when the filtered strobe edge is seen. The stimulus changes every bus input on the falling clock edge. It holds every address and data value for ten clocks around the strobe edge it belongs to, and it swaps data to a different value only after that window, so that a late sample would be caught.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

  typedef enum logic [2:0] {
    KIND_STANDBY = 3'd0,
    KIND_READ    = 3'd1,
    KIND_WRITE   = 3'd2,
    KIND_QUIET   = 3'd3,
    KIND_RESET   = 3'd4
  } bus_kind_e;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_ABORT = 2'd2
  } cap_state_e;

  localparam int N_STROBES = 4;
  localparam int IDX_CE    = 0;
  localparam int IDX_OE    = 1;
  localparam int IDX_WE    = 2;
  localparam int IDX_RP    = 3;

endpackage

// File: rtl/nbf_strobe_cond.sv
module nbf_strobe_cond #(
  parameter int FILT_CYC  = 4,
  parameter bit DO_FILTER = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic clean_n
);

  logic s1_q, s2_q;

  // two-flop synchroniser, idles at the inactive (high) level
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= raw_n;
      s2_q <= s1_q;
    end
  end

  generate
    if (DO_FILTER) begin : g_filt
      localparam int CW = $clog2(FILT_CYC + 1);
      localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
      localparam logic [CW-1:0] SAT  = CW'(FILT_CYC);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] run_q;
      logic          f_q;

      // accept a new level only after FILT_CYC consecutive differing samples
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q <= '0;
          f_q   <= 1'b1;
        end else if (s2_q != f_q) begin
          if (cnt_q == LAST) begin
            f_q   <= s2_q;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end

      // independent run-length of the synchronised level, for the check below
      always_ff @(posedge clk) begin
        if (!rst_n)             run_q <= '0;
        else if (s1_q != s2_q)  run_q <= '0;
        else if (run_q != SAT)  run_q <= run_q + 1'b1;
      end

      AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q != $past(f_q)) |-> ($past(run_q) >= LAST))
        else $error("filtered strobe moved before its input was stable"); // R2

      assign clean_n = f_q;
    end else begin : g_pass
      assign clean_n = s2_q;
    end
  endgenerate

endmodule

// File: rtl/nbf_cycle_decode.sv
module nbf_cycle_decode
  import nbf_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_f,
  input  logic          we_f,
  input  logic          rp_f,
  input  logic          oe_s,
  input  logic [PW-1:0] addr_lo,
  output bus_kind_e     kind_q,
  output logic [PW-1:0] page_q
);

  bus_kind_e kind_d;

  // priority: reset, standby, write, read, output disable
  always_comb begin
    if (!rp_f)      kind_d = KIND_RESET;
    else if (ce_f)  kind_d = KIND_STANDBY;
    else if (!we_f) kind_d = KIND_WRITE;
    else if (!oe_s) kind_d = KIND_READ;
    else            kind_d = KIND_QUIET;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= KIND_STANDBY;
      page_q <= '0;
    end else begin
      kind_q <= kind_d;
      page_q <= addr_lo;
    end
  end

endmodule

// File: rtl/nbf_write_capture.sv
module nbf_write_capture
  import nbf_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_f,
  input  logic          we_f,
  input  logic          rp_f,
  input  logic          oe_s,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_error
);

  cap_state_e state_q;
  logic       strobe_n;
  logic       strobe_prev_q;
  logic       strobe_fall;
  logic       strobe_rise;

  assign strobe_n    = ce_f | we_f;
  assign strobe_fall = strobe_prev_q & ~strobe_n;
  assign strobe_rise = ~strobe_prev_q & strobe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= CAP_IDLE;
      strobe_prev_q <= 1'b1;
      wr_valid      <= 1'b0;
      wr_error      <= 1'b0;
      wr_addr       <= '0;
      wr_data       <= '0;
    end else begin
      strobe_prev_q <= strobe_n;
      wr_valid      <= 1'b0;
      wr_error      <= 1'b0;
      unique case (state_q)
        CAP_IDLE: begin
          if (strobe_fall && rp_f) begin
            if (oe_s) begin
              wr_addr <= addr_in;
              state_q <= CAP_ARMED;
            end else begin
              wr_error <= 1'b1;
              state_q  <= CAP_ABORT;
            end
          end
        end
        CAP_ARMED: begin
          if (!rp_f) begin
            state_q <= CAP_IDLE;
          end else if (!oe_s) begin
            wr_error <= 1'b1;
            state_q  <= CAP_ABORT;
          end else if (strobe_rise) begin
            wr_data  <= data_in;
            wr_valid <= 1'b1;
            state_q  <= CAP_IDLE;
          end
        end
        CAP_ABORT: begin
          if (strobe_rise || !rp_f) state_q <= CAP_IDLE;
        end
        default: state_q <= CAP_IDLE;
      endcase
    end
  end

  AST_WR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid) else $error("write pulse longer than one clock"); // R8

  AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_error)) else $error("valid and error together"); // R11

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $stable(wr_addr)) else $error("address moved at data capture"); // R7

endmodule

// File: rtl/nor_bus_front.sv
module nor_bus_front
  import nbf_pkg::*;
#(
  parameter int AW         = 24,
  parameter int DW         = 16,
  parameter int FILT_CYC   = 4,
  parameter int PAGE_WORDS = 8,
  localparam int PW        = $clog2(PAGE_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_en_n,
  input  logic          out_en_n,
  input  logic          wr_en_n,
  input  logic          hw_rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_error,
  output logic          rd_active,
  output logic          dq_oe,
  output logic [PW-1:0] page_offset,
  output logic [2:0]    cycle_kind
);

  logic [N_STROBES-1:0] raw_n;
  logic [N_STROBES-1:0] clean_n;
  bus_kind_e            kind_q;

  assign raw_n[IDX_CE] = chip_en_n;
  assign raw_n[IDX_OE] = out_en_n;
  assign raw_n[IDX_WE] = wr_en_n;
  assign raw_n[IDX_RP] = hw_rst_n;

  // output enable is synchronised only; the others are also filtered
  for (genvar i = 0; i < N_STROBES; i++) begin : g_strobe
    nbf_strobe_cond #(
      .FILT_CYC (FILT_CYC),
      .DO_FILTER(i != IDX_OE)
    ) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_n  (raw_n[i]),
      .clean_n(clean_n[i])
    );
  end

  nbf_cycle_decode #(.PW(PW)) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_f   (clean_n[IDX_CE]),
    .we_f   (clean_n[IDX_WE]),
    .rp_f   (clean_n[IDX_RP]),
    .oe_s   (clean_n[IDX_OE]),
    .addr_lo(addr_in[PW-1:0]),
    .kind_q (kind_q),
    .page_q (page_offset)
  );

  nbf_write_capture #(.AW(AW), .DW(DW)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_f    (clean_n[IDX_CE]),
    .we_f    (clean_n[IDX_WE]),
    .rp_f    (clean_n[IDX_RP]),
    .oe_s    (clean_n[IDX_OE]),
    .addr_in (addr_in),
    .data_in (data_in),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_error(wr_error)
  );

  assign cycle_kind = kind_q;
  assign rd_active  = (kind_q == KIND_READ);
  assign dq_oe      = rd_active & ~clean_n[IDX_OE];

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(out_en_n, 2) |-> !dq_oe) else $error("drivers still on after OE high"); // R5

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_kind == KIND_RESET) |-> (!wr_valid && !dq_oe))
    else $error("activity during bus reset"); // R10

endmodule

// File: tb/sim_nor_bus_front.sv
module sim_nor_bus_front;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 24;
  localparam int DW   = 16;
  localparam int FILT = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, rp_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic          wr_valid, wr_error, rd_active, dq_oe;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [2:0]    page_offset;
  logic [2:0]    cycle_kind;

  int vectors  = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_bus_front #(.AW(AW), .DW(DW), .FILT_CYC(FILT), .PAGE_WORDS(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .chip_en_n(ce_n), .out_en_n(oe_n), .wr_en_n(we_n), .hw_rst_n(rp_n),
    .addr_in(addr), .data_in(data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_error(wr_error),
    .rd_active(rd_active), .dq_oe(dq_oe), .page_offset(page_offset),
    .cycle_kind(cycle_kind)
  );

  // ---------------- behavioural reference model ----------------
  int m_s1 [4];
  int m_s2 [4];
  int m_f  [4];
  int m_cnt[4];
  int m_prev, m_state, m_valid, m_err, m_kind, m_page;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  bit seen_rst = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_s1[i]) begin m_s1[i] = 1; m_s2[i] = 1; m_f[i] = 1; m_cnt[i] = 0; end
      m_prev = 1; m_state = 0; m_valid = 0; m_err = 0; m_kind = 0; m_page = 0;
      m_addr = '0; m_data = '0;
      seen_rst = 1;
    end else begin
      int oe_s, cef, wef, rpf, comb, fall, rise, nk;
      oe_s = m_s2[1]; cef = m_f[0]; wef = m_f[2]; rpf = m_f[3];
      comb = cef | wef;
      fall = (m_prev == 1 && comb == 0);
      rise = (m_prev == 0 && comb == 1);
      if (rpf == 0) nk = 4;
      else if (cef == 1) nk = 0;
      else if (wef == 0) nk = 2;
      else if (oe_s == 0) nk = 1;
      else nk = 3;
      m_valid = 0; m_err = 0;
      case (m_state)
        0: if (fall && rpf == 1) begin
             if (oe_s == 1) begin m_addr = addr; m_state = 1; end
             else begin m_err = 1; m_state = 2; end
           end
        1: if (rpf == 0) m_state = 0;
           else if (oe_s == 0) begin m_err = 1; m_state = 2; end
           else if (rise) begin m_data = data; m_valid = 1; m_state = 0; end
        default: if (rise || rpf == 0) m_state = 0;
      endcase
      m_kind = nk;
      m_page = int'(addr[2:0]);
      m_prev = comb;
      foreach (m_f[i]) begin
        if (i != 1) begin
          if (m_s2[i] != m_f[i]) begin
            if (m_cnt[i] == FILT - 1) begin m_f[i] = m_s2[i]; m_cnt[i] = 0; end
            else m_cnt[i] = m_cnt[i] + 1;
          end else m_cnt[i] = 0;
        end
      end
      m_s2 = m_s1;
      m_s1[0] = int'(ce_n); m_s1[1] = int'(oe_n); m_s1[2] = int'(we_n); m_s1[3] = int'(rp_n);
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // capture queues and per-cycle comparison
  logic [AW-1:0] got_a[$];
  logic [DW-1:0] got_d[$];
  int err_seen = 0;
  int busy_seen = 0;

  always @(negedge clk) begin
    if (seen_rst) begin
      cmp("R3 R4 cycle_kind", int'(cycle_kind), m_kind);
      cmp("R8 wr_valid", int'(wr_valid), m_valid);
      cmp("R9 wr_error", int'(wr_error), m_err);
      cmp("R7 wr_addr", int'(wr_addr), int'(m_addr));
      cmp("R7 wr_data", int'(wr_data), int'(m_data));
      cmp("R5 rd_active", int'(rd_active), int'(m_kind == 1));
      cmp("R5 dq_oe", int'(dq_oe), int'(m_kind == 1 && m_s2[1] == 0));
      cmp("R6 page_offset", int'(page_offset), m_page);
      cmp("R11 exclusive", int'(wr_valid && wr_error), 0);
    end
    if (rst_n && wr_valid) begin got_a.push_back(wr_addr); got_d.push_back(wr_data); end
    if (rst_n && wr_error) err_seen++;
    if (rst_n && cycle_kind != 3'd0) busy_seen++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write framed by ce and we; ce_lead: ce falls first and rises last
  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ce_lead);
    addr = 24'hFFFFFF;
    if (ce_lead) ce_n = 1'b0; else we_n = 1'b0;
    idle(10);
    addr = a;
    if (ce_lead) we_n = 1'b0; else ce_n = 1'b0;
    idle(10);
    data = d;
    idle(2);
    if (ce_lead) we_n = 1'b1; else ce_n = 1'b1;
    idle(10);
    data = ~d;
    if (ce_lead) ce_n = 1'b1; else we_n = 1'b1;
    idle(12);
  endtask

  task automatic expect_write(input string tag, input int n0,
                              input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmp({tag, " count"}, got_a.size(), n0 + 1);
    if (got_a.size() == n0 + 1) begin
      cmp({tag, " addr"}, int'(got_a[n0]), int'(a));
      cmp({tag, " data"}, int'(got_d[n0]), int'(d));
    end
  endtask

  initial begin
    int n0, e0;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; rp_n = 1'b1;
    addr = '0; data = '0;
    idle(4);
    cmp("R1 kind in reset", int'(cycle_kind), 0);
    rst_n = 1'b1;
    idle(1);
    cmp("R1 kind", int'(cycle_kind), 0);
    cmp("R1 outputs", int'({wr_valid, wr_error, rd_active, dq_oe, page_offset}), 0);

    // standby with OE low keeps drivers off
    oe_n = 1'b0; idle(12);
    cmp("R4 standby kind", int'(cycle_kind), 0);
    cmp("R5 standby dq_oe", int'(dq_oe), 0);
    oe_n = 1'b1; idle(4);

    // page read
    ce_n = 1'b0; idle(2); oe_n = 1'b0;
    for (int i = 0; i < 8; i++) begin addr = 24'h012340 + 24'(i * 3 % 8); idle(3); end
    idle(8);
    cmp("R5 read active", int'(rd_active), 1);
    cmp("R6 page", int'(page_offset), int'(addr[2:0]));
    oe_n = 1'b1; idle(2);
    cmp("R5 dq_oe release", int'(dq_oe), 0);
    idle(10);
    cmp("R4 output disable", int'(cycle_kind), 3);
    ce_n = 1'b1; idle(12);

    // writes in both strobe orders
    n0 = got_a.size();
    bus_write(24'h0A5A5A, 16'hBEEF, 1'b1);
    expect_write("R7 R8 ce-led write", n0, 24'h0A5A5A, 16'hBEEF);
    n0 = got_a.size();
    bus_write(24'h123456, 16'h1357, 1'b0);
    expect_write("R7 R8 we-led write", n0, 24'h123456, 16'h1357);

    // short chip-enable pulse ignored, FILT-long pulse accepted
    busy_seen = 0;
    ce_n = 1'b0; idle(FILT - 1); ce_n = 1'b1; idle(12);
    cmp("R2 short pulse ignored", busy_seen, 0);
    ce_n = 1'b0; idle(FILT); ce_n = 1'b1; idle(12);
    cmp("R2 full pulse accepted", int'(busy_seen != 0), 1);

    // write enable glitch inside a write does not split it
    n0 = got_a.size();
    addr = 24'h00ABCD; ce_n = 1'b0; we_n = 1'b0; idle(10);
    data = 16'h1111; we_n = 1'b1; idle(FILT - 1); we_n = 1'b0; idle(10);
    data = 16'h2222; idle(2); we_n = 1'b1; idle(10); ce_n = 1'b1; data = 16'h0; idle(12);
    expect_write("R2 R7 glitched write", n0, 24'h00ABCD, 16'h2222);

    // OE low during an armed write
    n0 = got_a.size(); e0 = err_seen;
    addr = 24'h000777; ce_n = 1'b0; we_n = 1'b0; idle(10);
    oe_n = 1'b0; idle(5); oe_n = 1'b1; idle(5);
    we_n = 1'b1; ce_n = 1'b1; idle(12);
    cmp("R9 armed discard count", got_a.size(), n0);
    cmp("R9 armed error pulse", err_seen, e0 + 1);

    // OE already low when the strobe falls
    e0 = err_seen;
    oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; idle(10);
    oe_n = 1'b1; we_n = 1'b1; ce_n = 1'b1; idle(12);
    cmp("R9 early discard count", got_a.size(), n0);
    cmp("R9 early error pulse", err_seen, e0 + 1);

    // hardware reset abandons a write
    e0 = err_seen;
    addr = 24'h00F00D; ce_n = 1'b0; we_n = 1'b0; idle(10);
    rp_n = 1'b0; idle(10);
    cmp("R10 reset kind", int'(cycle_kind), 4);
    rp_n = 1'b1; idle(10);
    we_n = 1'b1; ce_n = 1'b1; idle(12);
    cmp("R10 no write after reset", got_a.size(), n0);
    cmp("R10 no error after reset", err_seen, e0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

endmodule